// File: doc/BRIEF.md
# Guest-Tagged Address Translation Cache

This block is a small fully associative cache of finished address translations. Each slot holds one combined mapping from a guest virtual page straight to a machine physical page, with both translation stages already folded together. Each slot is tagged with the identifier of the guest that owns it. Slots from several guests live side by side, so switching the running guest needs no flush. A page walker outside the block installs results through a fill port. Maintenance logic removes slots through an invalidate port that clears everything, clears one guest's slots, or clears one page of one guest.

A lookup presents a virtual page number and a guest identifier. The answer appears one clock later: a response-valid strobe, hit, the physical page number, the permission bits, and a multi-hit flag. The identifier compare has two configuration controls. A width control selects 8-bit or 16-bit identifiers. An ignore mask lets a group of guests hit the same slot. Each slot records its own page size (4 KB, 16 KB or 64 KB), so slots of different sizes can sit side by side.

Top module: `vm_tlb`

## Requirements
- R1: After reset no slot is valid, `rsp_valid`, `rsp_hit` and `rsp_multi` are low, and any lookup misses.
- R2: A lookup presented with `lk_valid` in one cycle gives `rsp_valid` on the next clock edge. On a hit, `rsp_hit` is high and `rsp_ppn` and `rsp_perm` carry the stored mapping.
- R3: A slot hits only when its stored guest identifier equals the requester's identifier, after the ignored bits are removed.
- R4: With `cfg_vmid16` = 1 all 16 identifier bits are compared. With `cfg_vmid16` = 0 bits 15:8 are ignored in lookups and in invalidations.
- R5: Every bit set in `cfg_vmid_mask` is ignored in identifier compares.
- R6: Page-size code 0 (4 KB) compares every VPN bit. Code 1 (16 KB) ignores VPN bits 1:0. Code 2 (64 KB) ignores VPN bits 3:0. Code 3 acts as 4 KB. For the ignored bits, the returned PPN takes the low bits from the request VPN.
- R7: A fill goes into the lowest-index invalid slot. When all slots are valid it replaces the slot named by a round-robin pointer. The pointer starts at 0 and moves up by one on each fill that finds no free slot.
- R8: Invalidate code 0 clears every slot. Code 3 changes nothing.
- R9: Invalidate code 1 clears every slot whose identifier matches `inv_vmid` under the same masking as lookups.
- R10: Invalidate code 2 clears slots whose identifier matches `inv_vmid` and whose page, at that slot's own size, contains `inv_vpn`.
- R11: When more than one slot matches, the lowest-index slot supplies the data and `rsp_multi` is raised together with `rsp_hit`.
- R12: A lookup sees the contents from before any fill or invalidate in the same cycle. When a fill and an invalidate fall in the same cycle, the invalidate is applied first and the filled slot ends up valid.
- R13: On a miss, `rsp_ppn` and `rsp_perm` are zero and `rsp_multi` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_vmid16 | input | 1 | 1: 16-bit identifiers, 0: 8-bit |
| cfg_vmid_mask | input | 16 | Identifier bits ignored in compares |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_vmid | input | 16 | Lookup guest identifier |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Fill virtual page number |
| fill_vmid | input | 16 | Fill guest identifier |
| fill_size | input | 2 | Fill page-size code |
| fill_ppn | input | PPN_W | Fill physical page number |
| fill_perm | input | PERM_W | Fill permission bits |
| inv_valid | input | 1 | Invalidate command |
| inv_op | input | 2 | 0 all, 1 by identifier, 2 by page and identifier, 3 none |
| inv_vpn | input | VPN_W | Invalidate page |
| inv_vmid | input | 16 | Invalidate identifier |
| rsp_valid | output | 1 | Response strobe, one cycle after a lookup |
| rsp_hit | output | 1 | Lookup hit |
| rsp_multi | output | 1 | More than one slot matched |
| rsp_ppn | output | PPN_W | Physical page number |
| rsp_perm | output | PERM_W | Permission bits |

## Verification
The functions most likely to collide are a lookup and a state change in the same clock: a fill or an invalidate-all landing together with a lookup, and a fill landing together with an invalidate. The bench drives all three in one cycle. The lookup must return the old mapping. Afterwards the old page must miss and the freshly filled page must hit. A second case drives a lookup and a fill of the same page together and expects a miss first and a hit on the next lookup.

// File: rtl/vm_tlb.sv
module vm_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 36,
  parameter int PPN_W   = 28,
  parameter int PERM_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_vmid16,
  input  logic [15:0]       cfg_vmid_mask,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [15:0]       lk_vmid,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [15:0]       fill_vmid,
  input  logic [1:0]        fill_size,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              inv_valid,
  input  logic [1:0]        inv_op,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [15:0]       inv_vmid,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_multi,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic [PERM_W-1:0] rsp_perm
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [1:0] OP_ALL = 2'd0, OP_VMID = 2'd1, OP_ADDR = 2'd2;

  function automatic logic [3:0] size_lo(input logic [1:0] sz);
    case (sz)
      2'd1:    size_lo = 4'b0011;
      2'd2:    size_lo = 4'b1111;
      default: size_lo = 4'b0000;
    endcase
  endfunction

  logic [ENTRIES-1:0] valid;
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [15:0]        e_vmid [ENTRIES];
  logic [1:0]         e_size [ENTRIES];
  logic [PPN_W-1:0]   e_ppn  [ENTRIES];
  logic [PERM_W-1:0]  e_perm [ENTRIES];

  logic [IDX_W-1:0]   rr_ptr, free_idx, victim, sel;
  logic               has_free, any_hit;
  logic [ENTRIES-1:0] lk_match, inv_clr, fill_vec;

  wire [15:0] vid_ign = cfg_vmid_mask | (cfg_vmid16 ? 16'h0000 : 16'hFF00);
  wire        multi   = (lk_match & (lk_match - 1'b1)) != '0;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    wire [VPN_W-1:0] em      = VPN_W'(size_lo(e_size[g]));
    wire             lk_vid  = ((e_vmid[g] ^ lk_vmid) & ~vid_ign) == 16'h0;
    wire             lk_adr  = ((e_vpn[g] ^ lk_vpn) & ~em) == '0;
    wire             iv_vid  = ((e_vmid[g] ^ inv_vmid) & ~vid_ign) == 16'h0;
    wire             iv_adr  = ((e_vpn[g] ^ inv_vpn) & ~em) == '0;
    assign lk_match[g] = valid[g] && lk_vid && lk_adr;
    assign inv_clr[g]  = inv_valid && ((inv_op == OP_ALL) ||
                                       (inv_op == OP_VMID && iv_vid) ||
                                       (inv_op == OP_ADDR && iv_vid && iv_adr));
    assign fill_vec[g] = fill_valid && (victim == IDX_W'(g));
  end

  always_comb begin
    sel = '0;
    any_hit = 1'b0;
    free_idx = '0;
    has_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i]) begin
        sel = IDX_W'(i);
        any_hit = 1'b1;
      end
      if (!valid[i]) begin
        free_idx = IDX_W'(i);
        has_free = 1'b1;
      end
    end
  end

  assign victim = has_free ? free_idx : rr_ptr;

  wire [PPN_W-1:0] pmask  = PPN_W'(size_lo(e_size[sel]));
  wire [PPN_W-1:0] merged = (e_ppn[sel] & ~pmask) | (PPN_W'(lk_vpn[3:0]) & pmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid     <= '0;
      rr_ptr    <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_ppn   <= '0;
      rsp_perm  <= '0;
    end else begin
      valid <= (valid & ~inv_clr) | fill_vec;
      if (fill_valid && !has_free)
        rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && any_hit;
      rsp_multi <= lk_valid && any_hit && multi;
      rsp_ppn   <= (lk_valid && any_hit) ? merged : '0;
      rsp_perm  <= (lk_valid && any_hit) ? e_perm[sel] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      e_vpn[victim]  <= fill_vpn;
      e_vmid[victim] <= fill_vmid;
      e_size[victim] <= fill_size;
      e_ppn[victim]  <= fill_ppn;
      e_perm[victim] <= fill_perm;
    end
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R2
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_hit && !rsp_multi); // R1
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0 && rsp_perm == '0 && !rsp_multi)); // R13
  AST_MULTI_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> rsp_hit); // R11
  AST_INV_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_op == OP_ALL && !fill_valid) |=> valid == '0); // R8
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> valid[$past(victim)]); // R12
endmodule

// File: tb/test_vm_tlb.sv
module test_vm_tlb;
  localparam int VPN_W = 36, PPN_W = 28, PERM_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_vmid16 = 1'b1;
  logic [15:0] cfg_vmid_mask = '0;
  logic lk_valid = 1'b0, fill_valid = 1'b0, inv_valid = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0, fill_vpn = '0, inv_vpn = '0;
  logic [15:0] lk_vmid = '0, fill_vmid = '0, inv_vmid = '0;
  logic [1:0] fill_size = '0, inv_op = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic [PERM_W-1:0] fill_perm = '0;
  logic rsp_valid, rsp_hit, rsp_multi;
  logic [PPN_W-1:0] rsp_ppn;
  logic [PERM_W-1:0] rsp_perm;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  vm_tlb i_vm_tlb (.*);

  task automatic expect_rsp(string tag, logic hit, logic [PPN_W-1:0] ppn,
                            logic [PERM_W-1:0] perm, logic multi);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_hit !== hit || rsp_ppn !== ppn ||
        rsp_perm !== perm || rsp_multi !== multi) begin
      failures++;
      $display("FAIL %s: v=%0b hit=%0b ppn=%h perm=%h multi=%0b expected v=1 hit=%0b ppn=%h perm=%h multi=%0b",
               tag, rsp_valid, rsp_hit, rsp_ppn, rsp_perm, rsp_multi, hit, ppn, perm, multi);
    end
  endtask

  task automatic lookup(string tag, logic [VPN_W-1:0] vpn, logic [15:0] vmid, logic hit,
                        logic [PPN_W-1:0] ppn, logic [PERM_W-1:0] perm, logic multi = 1'b0);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = vpn; lk_vmid = vmid;
    @(negedge clk);
    lk_valid = 1'b0;
    expect_rsp(tag, hit, ppn, perm, multi);
  endtask

  task automatic fill(logic [VPN_W-1:0] vpn, logic [15:0] vmid, logic [1:0] sz,
                      logic [PPN_W-1:0] ppn, logic [PERM_W-1:0] perm);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_vmid = vmid; fill_size = sz;
    fill_ppn = ppn; fill_perm = perm;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic inval(logic [1:0] op, logic [VPN_W-1:0] vpn, logic [15:0] vmid);
    @(negedge clk);
    inv_valid = 1'b1; inv_op = op; inv_vpn = vpn; inv_vmid = vmid;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic t_reset;
    checks++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_multi !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset outputs: v=%0b hit=%0b multi=%0b expected 0 0 0",
               rsp_valid, rsp_hit, rsp_multi);
    end
    lookup("R1 empty miss", 36'h0, 16'h0, 1'b0, '0, '0);
  endtask

  task automatic t_basic_and_vmid;
    fill(36'h12345, 16'h0101, 2'd0, 28'hABCDE, 3'd5);
    lookup("R2 hit data", 36'h12345, 16'h0101, 1'b1, 28'hABCDE, 3'd5);
    lookup("R13 miss zero", 36'h12346, 16'h0101, 1'b0, '0, '0);
    lookup("R3 other guest", 36'h12345, 16'h0102, 1'b0, '0, '0);
    lookup("R4 16-bit upper differs", 36'h12345, 16'h0201, 1'b0, '0, '0);
    cfg_vmid16 = 1'b0;
    lookup("R4 8-bit upper ignored", 36'h12345, 16'h0201, 1'b1, 28'hABCDE, 3'd5);
    cfg_vmid16 = 1'b1;
    cfg_vmid_mask = 16'h0003;
    lookup("R5 masked guest shares", 36'h12345, 16'h0102, 1'b1, 28'hABCDE, 3'd5);
    cfg_vmid_mask = 16'h0000;
  endtask

  task automatic t_page_sizes;
    inval(2'd0, '0, '0);
    fill(36'h400, 16'h1, 2'd2, 28'h7770, 3'd1);
    fill(36'h800, 16'h1, 2'd1, 28'h5550, 3'd2);
    lookup("R6 64K inside", 36'h40B, 16'h1, 1'b1, 28'h777B, 3'd1);
    lookup("R6 64K outside", 36'h410, 16'h1, 1'b0, '0, '0);
    lookup("R6 16K inside", 36'h803, 16'h1, 1'b1, 28'h5553, 3'd2);
    lookup("R6 16K outside", 36'h804, 16'h1, 1'b0, '0, '0);
    inval(2'd3, '0, '0);
    lookup("R8 code 3 no effect", 36'h800, 16'h1, 1'b1, 28'h5550, 3'd2);
    inval(2'd0, '0, '0);
    lookup("R8 all cleared a", 36'h400, 16'h1, 1'b0, '0, '0);
    lookup("R8 all cleared b", 36'h800, 16'h1, 1'b0, '0, '0);
  endtask

  task automatic t_inv_vmid;
    inval(2'd0, '0, '0);
    fill(36'h1, 16'h1, 2'd0, 28'h11, 3'd1);
    fill(36'h2, 16'h2, 2'd0, 28'h22, 3'd1);
    fill(36'h3, 16'h3, 2'd0, 28'h33, 3'd1);
    inval(2'd1, '0, 16'h2);
    lookup("R9 target cleared", 36'h2, 16'h2, 1'b0, '0, '0);
    lookup("R9 other kept", 36'h1, 16'h1, 1'b1, 28'h11, 3'd1);
    cfg_vmid_mask = 16'h0001;
    inval(2'd1, '0, 16'h0);
    cfg_vmid_mask = 16'h0000;
    lookup("R9 masked clears guest 1", 36'h1, 16'h1, 1'b0, '0, '0);
    lookup("R9 masked keeps guest 3", 36'h3, 16'h3, 1'b1, 28'h33, 3'd1);
  endtask

  task automatic t_inv_addr;
    inval(2'd0, '0, '0);
    fill(36'h20, 16'h5, 2'd2, 28'h900, 3'd3);
    fill(36'h50, 16'h5, 2'd0, 28'h950, 3'd4);
    fill(36'h50, 16'h6, 2'd0, 28'h960, 3'd6);
    inval(2'd2, 36'h23, 16'h5);
    lookup("R10 64K page cleared", 36'h20, 16'h5, 1'b0, '0, '0);
    inval(2'd2, 36'h50, 16'h6);
    lookup("R10 same page other guest kept", 36'h50, 16'h5, 1'b1, 28'h950, 3'd4);
    lookup("R10 guest 6 page cleared", 36'h50, 16'h6, 1'b0, '0, '0);
  endtask

  task automatic t_replace;
    inval(2'd0, '0, '0);
    for (int i = 0; i < 16; i++) fill(VPN_W'(i), 16'h7, 2'd0, PPN_W'(32'h100 + i), 3'd1);
    lookup("R7 full set holds last", 36'hF, 16'h7, 1'b1, 28'h10F, 3'd1);
    fill(36'h99, 16'h7, 2'd0, 28'h199, 3'd1);
    lookup("R7 slot 0 replaced", 36'h0, 16'h7, 1'b0, '0, '0);
    lookup("R7 slot 1 kept", 36'h1, 16'h7, 1'b1, 28'h101, 3'd1);
    inval(2'd2, 36'h5, 16'h7);
    fill(36'h98, 16'h7, 2'd0, 28'h198, 3'd1);
    fill(36'h97, 16'h7, 2'd0, 28'h197, 3'd1);
    lookup("R7 free slot preferred", 36'h2, 16'h7, 1'b1, 28'h102, 3'd1);
    lookup("R7 pointer moved to slot 1", 36'h1, 16'h7, 1'b0, '0, '0);
    lookup("R7 free-slot fill present", 36'h98, 16'h7, 1'b1, 28'h198, 3'd1);
  endtask

  task automatic t_multi;
    inval(2'd0, '0, '0);
    fill(36'h60, 16'h8, 2'd0, 28'hA, 3'd1);
    fill(36'h60, 16'h8, 2'd0, 28'hB, 3'd2);
    lookup("R11 lowest wins with flag", 36'h60, 16'h8, 1'b1, 28'hA, 3'd1, 1'b1);
  endtask

  task automatic t_same_cycle;
    inval(2'd0, '0, '0);
    fill(36'h70, 16'h9, 2'd0, 28'hC, 3'd1);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = 36'h70; lk_vmid = 16'h9;
    inv_valid = 1'b1; inv_op = 2'd0;
    fill_valid = 1'b1; fill_vpn = 36'h71; fill_vmid = 16'h9; fill_size = 2'd0;
    fill_ppn = 28'hD; fill_perm = 3'd2;
    @(negedge clk);
    lk_valid = 1'b0; inv_valid = 1'b0; fill_valid = 1'b0;
    expect_rsp("R12 lookup sees old state", 1'b1, 28'hC, 3'd1, 1'b0);
    lookup("R12 old entry gone", 36'h70, 16'h9, 1'b0, '0, '0);
    lookup("R12 fill survives invalidate", 36'h71, 16'h9, 1'b1, 28'hD, 3'd2);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = 36'h72; lk_vmid = 16'h9;
    fill_valid = 1'b1; fill_vpn = 36'h72; fill_ppn = 28'hE; fill_perm = 3'd3;
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0;
    expect_rsp("R12 lookup before own fill", 1'b0, '0, '0, 1'b0);
    lookup("R12 fill visible next", 36'h72, 16'h9, 1'b1, 28'hE, 3'd3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_and_vmid();
    t_page_sizes();
    t_inv_vmid();
    t_inv_addr();
    t_replace();
    t_multi();
    t_same_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule